// File: doc/BRIEF.md
# Two-Level Interrupt Priority Resolver

This block collects interrupt request lines from on-chip sources and, on each clock, names the single request that should be serviced next. Each request line has a fixed vector number. Every line except the non-maskable one belongs to a module group. A small control register holds one bit per group, and that bit places the whole group at level 1 (urgent) or level 0 (normal). The non-maskable line sits above both levels. Inside a level the lowest vector number wins.

A request line sets a pending flag on its rising edge. The flag stays set until the interrupt handler acknowledges it by sending that source's vector number. The block gives out a registered valid flag, the winning vector number and its vector address, which is the vector times four. A global enable input blocks new maskable requests but never the non-maskable one.

Source map (request input bit → vector): bit 0 → 7 (non-maskable); bits 1..8 → 16..23 (external lines 0..7); bit 9 → 24; bits 10..11 → 25, 26; bit 12 → 27; bit 13 → 28; bit 14 → 29; bits 15..17 → 44, 45, 46; bits 18..20 → 52, 53, 54. Group map (control bit → request bits): control bits 0..7 → request bits 1..8, one each; 8 → 9; 9 → 10, 11; 10 → 12; 11 → 13; 12 → 14; 13 → 15..17; 14 → 18..20.

Top module: `intr_prio_resolver`

## Requirements
- R1: A pending non-maskable request (bit 0, vector 7) wins over every other pending request at either level, and it has no control bit.
- R2: A pending request whose group control bit is 1 wins over every pending request whose group control bit is 0.
- R3: Among pending requests at the same level, the one with the lowest vector number wins.
- R4: Sources of one group share its control bit and keep their fixed vector order inside the group (for example 44 before 45 before 46).
- R5: `irqAddr` equals `irqVector` times 4, zero-extended to 24 bits (vector 44 → 0x0000B0, vector 54 → 0x0000D8, vector 7 → 0x00001C).
- R6: A request is captured only on a 0→1 transition of its input. A line held high is captured once, and it is captured again only after it falls and rises again.
- R7: An acknowledge clears only the source whose vector equals `ackVector`. An acknowledge with a vector that matches no source has no effect. A rising edge in the same cycle as the acknowledge of that source leaves it pending.
- R8: A write to the control register changes arbitration from the next clock. The outputs registered at the write edge still use the old levels.
- R9: The outputs are registered. They show the winner of the pending set and the levels as they stood at the previous clock edge.
- R10: When nothing is pending, `irqValid`, `irqVector` and `irqAddr` are all zero.
- R11: While `irqEnable` is low, rising edges on maskable lines are not captured. Rising edges on the non-maskable line still are.
- R12: While `rstN` is low, all pending flags, all control bits and all outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| irqEnable | input | 1 | Global enable for maskable request capture |
| reqIn | input | 21 | Request lines, bit map as above |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 15 | New group level bits (1 = urgent) |
| ackValid | input | 1 | Acknowledge strobe |
| ackVector | input | 8 | Vector number being acknowledged |
| irqValid | output | 1 | A request is pending |
| irqVector | output | 8 | Winning vector number, 0 when idle |
| irqAddr | output | 24 | Winning vector address |

## Verification
The bench aims at orderings that a naive priority encoder gets wrong. A design that ignored the levels would pick vector 20 over a raised timer group. A design that compared only levels would let a level-1 group beat the non-maskable request. A design that treated levels per source would break the 44/45/46 order. The bench also targets edge capture: a level-sensitive latch would re-arm a line that is still held high after its acknowledge, and a clear-over-set ordering would lose a request that rises in the same cycle as its acknowledge. It also checks write timing and enable gating, which an unregistered level path or a gate that also masked the non-maskable line would get wrong.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;

  localparam int NUM_SRC = 21;
  localparam int NUM_GRP = 15;
  localparam int VEC_W   = 8;
  localparam int ADDR_W  = 24;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NO_GRP  = NUM_GRP;
  localparam int NMI_IDX = 0;
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(7);

  // Vector number of each request bit; index order is ascending vector order.
  function automatic logic [VEC_W-1:0] srcVector(input int idx);
    if (idx == NMI_IDX)  return NMI_VEC;
    else if (idx <= 14)  return VEC_W'(15 + idx);
    else if (idx <= 17)  return VEC_W'(29 + idx);
    else                 return VEC_W'(34 + idx);
  endfunction

  // Group (control bit) of each request bit; NO_GRP for the non-maskable line.
  function automatic int srcGroup(input int idx);
    if (idx == NMI_IDX)  return NO_GRP;
    else if (idx <= 8)   return idx - 1;
    else if (idx == 9)   return 8;
    else if (idx <= 11)  return 9;
    else if (idx <= 14)  return idx - 2;
    else if (idx <= 17)  return 13;
    else                 return 14;
  endfunction

  typedef struct packed {
    logic [NUM_SRC-1:0] clrMask;
    logic               winValid;
    logic [IDX_W-1:0]   winIdx;
  } strobe_t;

endpackage

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl
  import intr_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [NUM_GRP-1:0] cfgWrData,
  input  logic               ackValid,
  input  logic [VEC_W-1:0]   ackVector,
  input  logic [NUM_SRC-1:0] pendQ,
  output strobe_t            strb
);

  logic [NUM_GRP-1:0] levelQ;
  logic [NUM_SRC-1:0] srcHigh;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] highPend;

  always_ff @(posedge clk) begin
    if (!rstN)        levelQ <= '0;
    else if (cfgWrEn) levelQ <= cfgWrData;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int GRP = srcGroup(i);
    localparam logic [VEC_W-1:0] VEC = srcVector(i);
    if (GRP == NO_GRP) begin : g_fixed
      assign srcHigh[i] = 1'b1;
    end else begin : g_grp
      assign srcHigh[i] = levelQ[GRP];
    end
    assign clrMask[i] = ackValid && (ackVector == VEC);
  end

  assign highPend = pendQ & srcHigh;

  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_SRC-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    strb.clrMask  = clrMask;
    strb.winValid = |pendQ;
    strb.winIdx   = (|highPend) ? firstSet(highPend) : firstSet(pendQ);
  end

  // Vectors are unique, so one acknowledge clears at most one source.
  assert_clear_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrMask));

  // Any pending urgent source forces the chosen source to be urgent.
  assert_level_win_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|highPend) |-> (pendQ[strb.winIdx] && srcHigh[strb.winIdx]));

endmodule

// File: rtl/intr_prio_dp.sv
module intr_prio_dp
  import intr_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               irqEnable,
  input  logic [NUM_SRC-1:0] reqIn,
  input  strobe_t            strb,
  output logic [NUM_SRC-1:0] pendQ,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic [ADDR_W-1:0]  irqAddr
);

  localparam logic [NUM_SRC-1:0] MASKABLE = ~(NUM_SRC'(1) << NMI_IDX);

  logic [NUM_SRC-1:0] reqPrevQ;
  logic [NUM_SRC-1:0] riseMask;
  logic [NUM_SRC-1:0] acceptMask;
  logic [NUM_SRC-1:0] pendD;
  logic [VEC_W-1:0]   winVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_acc
    if (srcGroup(i) == NO_GRP) begin : g_nmi
      assign acceptMask[i] = 1'b1;
    end else begin : g_mask
      assign acceptMask[i] = irqEnable;
    end
  end

  assign riseMask = reqIn & ~reqPrevQ;
  // A new edge beats a clear for the same source.
  assign pendD    = (pendQ & ~strb.clrMask) | (riseMask & acceptMask);

  always_comb begin
    winVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.winIdx == IDX_W'(i)) winVec = srcVector(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrevQ  <= '0;
      pendQ     <= '0;
      irqValid  <= 1'b0;
      irqVector <= '0;
      irqAddr   <= '0;
    end else begin
      reqPrevQ  <= reqIn;
      pendQ     <= pendD;
      irqValid  <= strb.winValid;
      irqVector <= strb.winValid ? winVec : '0;
      irqAddr   <= strb.winValid ? (ADDR_W'(winVec) << 2) : '0;
    end
  end

  assert_nmi_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    pendQ[NMI_IDX] |=> (irqValid && irqVector == NMI_VEC));

  assert_addr_scale_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqAddr == (ADDR_W'(irqVector) << 2));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|pendQ) |=> irqValid);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(|pendQ) |=> (!irqValid && irqVector == '0 && irqAddr == '0));

  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |=> ((pendQ & ~$past(pendQ) & MASKABLE) == '0));

endmodule

// File: rtl/intr_prio_resolver.sv
module intr_prio_resolver
  import intr_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               irqEnable,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               cfgWrEn,
  input  logic [NUM_GRP-1:0] cfgWrData,
  input  logic               ackValid,
  input  logic [VEC_W-1:0]   ackVector,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic [ADDR_W-1:0]  irqAddr
);

  strobe_t            strb;
  logic [NUM_SRC-1:0] pendQ;

  intr_prio_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .ackValid  (ackValid),
    .ackVector (ackVector),
    .pendQ     (pendQ),
    .strb      (strb)
  );

  intr_prio_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqEnable (irqEnable),
    .reqIn     (reqIn),
    .strb      (strb),
    .pendQ     (pendQ),
    .irqValid  (irqValid),
    .irqVector (irqVector),
    .irqAddr   (irqAddr)
  );

endmodule

// File: tb/tb_intr_prio_resolver.sv
`timescale 1ns/1ps
module tb_intr_prio_resolver;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqEnable = 1'b0;
  logic [20:0] reqIn = '0;
  logic        cfgWrEn = 1'b0;
  logic [14:0] cfgWrData = '0;
  logic        ackValid = 1'b0;
  logic [7:0]  ackVector = '0;
  logic        irqValid;
  logic [7:0]  irqVector;
  logic [23:0] irqAddr;

  int errors = 0;
  int checks = 0;
  bit seenEdge = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  intr_prio_resolver dut (
    .clk(clk), .rstN(rstN), .irqEnable(irqEnable), .reqIn(reqIn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .ackValid(ackValid),
    .ackVector(ackVector), .irqValid(irqValid), .irqVector(irqVector),
    .irqAddr(irqAddr)
  );

  // Reference model: source table written from the requirements.
  int vecTab[21] = '{7, 16, 17, 18, 19, 20, 21, 22, 23, 24, 25, 26, 27, 28, 29,
                     44, 45, 46, 52, 53, 54};
  int grpTab[21] = '{-1, 0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 9, 10, 11, 12,
                     13, 13, 13, 14, 14, 14};
  bit [20:0] mPend, mPrev;
  bit [14:0] mCtrl;
  bit        mValid;
  int        mVec;

  always @(posedge clk) begin
    seenEdge <= 1;
    if (!rstN) begin
      mPend = '0; mPrev = '0; mCtrl = '0; mValid = 0; mVec = 0;
    end else begin
      int best, bestLvl;
      best = -1; bestLvl = -1;
      for (int i = 0; i < 21; i++) begin
        if (mPend[i]) begin
          int lvl;
          lvl = (grpTab[i] < 0) ? 2 : int'(mCtrl[grpTab[i]]);
          if (lvl > bestLvl || (lvl == bestLvl && vecTab[i] < vecTab[best])) begin
            best = i; bestLvl = lvl;
          end
        end
      end
      mValid = (best >= 0);
      mVec   = (best >= 0) ? vecTab[best] : 0;
      for (int i = 0; i < 21; i++) begin
        if (ackValid && int'(ackVector) == vecTab[i]) mPend[i] = 0;
        if (reqIn[i] && !mPrev[i] && (irqEnable || grpTab[i] < 0)) mPend[i] = 1;
      end
      mPrev = reqIn;
      if (cfgWrEn) mCtrl = cfgWrData;
    end
  end

  // R9: registered outputs compared with the model on every clock.
  always @(negedge clk) begin
    if (seenEdge && !finished) begin
      checks++;
      if (irqValid !== mValid || int'(irqVector) !== mVec || int'(irqAddr) !== mVec * 4) begin
        errors++;
        $display("FAIL R9 model t=%0t: valid=%0b vec=%0d addr=%0h expected valid=%0b vec=%0d addr=%0h",
                 $time, irqValid, irqVector, irqAddr, mValid, mVec, mVec * 4);
      end
    end
  end

  task automatic chk(input bit ev, input int evec, input string tag);
    checks++;
    if (irqValid !== ev || int'(irqVector) !== evec || int'(irqAddr) !== evec * 4) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%0d addr=%0h expected valid=%0b vec=%0d addr=%0h",
               tag, irqValid, irqVector, irqAddr, ev, evec, evec * 4);
    end
  endtask

  task automatic chkAddr(input int eaddr, input string tag);
    checks++;
    if (int'(irqAddr) !== eaddr) begin
      errors++;
      $display("FAIL %s: addr=%0h expected %0h", tag, irqAddr, eaddr);
    end
  endtask

  task automatic raise(input logic [20:0] m);
    reqIn = reqIn | m;
    @(negedge clk);
    reqIn = reqIn & ~m;
    @(negedge clk);
  endtask

  task automatic ack(input int v);
    ackValid = 1; ackVector = 8'(v);
    @(negedge clk);
    ackValid = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [14:0] d);
    cfgWrEn = 1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
    @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(0, 0, "R12 reset outputs");
    rstN = 1; irqEnable = 1;
    @(negedge clk);
    chk(0, 0, "R10 idle");

    raise((21'd1 << 5) | (21'd1 << 17));
    chk(1, 20, "R3 lowest vector at level 0");

    cfgWrEn = 1; cfgWrData = 15'd1 << 13;
    @(negedge clk);
    cfgWrEn = 0;
    chk(1, 20, "R8 old level at write edge");
    @(negedge clk);
    chk(1, 46, "R2 urgent group wins");

    raise((21'd1 << 15) | (21'd1 << 16));
    chk(1, 44, "R4 group order 44 first");
    chkAddr(24'h0000B0, "R5 vector 44 address");
    ack(44);
    chk(1, 45, "R7 ack clears 44");
    ack(99);
    chk(1, 45, "R7 unmatched ack ignored");
    ack(45);
    chk(1, 46, "R4 group order 46 last");
    ack(46);
    chk(1, 20, "R7 back to level 0");

    reqIn[1] = 1;
    @(negedge clk); @(negedge clk);
    chk(1, 16, "R3 vector 16 before 20");
    ack(16);
    chk(1, 20, "R6 held line not recaptured");
    reqIn[1] = 0;
    @(negedge clk);
    raise(21'd1 << 1);
    chk(1, 16, "R6 new edge recaptured");
    ack(16);
    chk(1, 20, "R7 ack 16");

    irqEnable = 0;
    raise(21'd1 << 2);
    chk(1, 20, "R11 maskable edge ignored");
    raise(21'd1);
    chk(1, 7, "R11 non-maskable accepted");
    chkAddr(24'h00001C, "R5 vector 7 address");
    ack(7);
    irqEnable = 1;
    @(negedge clk);
    chk(1, 20, "R11 masked edge not pending later");

    wr(15'h7FFF);
    chk(1, 20, "R2 all urgent");
    raise(21'd1 | (21'd1 << 20));
    chk(1, 7, "R1 non-maskable beats urgent");
    ack(7);
    chk(1, 20, "R3 order inside level 1");
    wr(15'd1 << 14);
    chk(1, 54, "R2 group 14 urgent");
    chkAddr(24'h0000D8, "R5 vector 54 address");
    ack(54);
    ack(20);
    chk(0, 0, "R10 idle after acks");

    reqIn[9] = 1; ackValid = 1; ackVector = 8'd24;
    @(negedge clk);
    reqIn[9] = 0; ackValid = 0;
    @(negedge clk);
    chk(1, 24, "R7 edge beats same-cycle ack");
    ack(24);
    chk(0, 0, "R10 idle");

    raise(21'd1 << 3);
    rstN = 0;
    @(negedge clk); @(negedge clk);
    chk(0, 0, "R12 reset clears pending");
    rstN = 1;
    raise((21'd1 << 15) | (21'd1 << 1));
    chk(1, 16, "R12 reset clears levels");
    ack(16); ack(44);
    chk(0, 0, "R10 idle");

    for (int n = 0; n < 600; n++) begin
      reqIn     = 21'($urandom) & 21'($urandom);
      ackValid  = irqValid && ($urandom % 3 == 0);
      ackVector = ($urandom % 10 == 0) ? 8'd99 : irqVector;
      cfgWrEn   = ($urandom % 16 == 0);
      cfgWrData = 15'($urandom);
      irqEnable = ($urandom % 8) != 0;
      @(negedge clk);
    end
    reqIn = '0; ackValid = 0; cfgWrEn = 0;
    @(negedge clk);
    finish();
  end

endmodule